// File: doc/BRIEF.md
# Shared Online Checker Scheduler

This block lends one trusted reference checker to several monitored accelerator units in turn. Units are visited in a fixed rotating order. Each unit owns a window whose length in clock cycles is set separately for each unit. A window opens with a dead interval, also set per unit, while the reference checker is being re-targeted to that unit's function. During the rest of the window the block raises `chk_active_o`. The sample source uses that signal to feed one identical input to both the monitored unit and the reference. The block then pairs the two returned results and compares them.

The pairing repeats for as long as the window lasts, so that faults which show up only now and then are caught over many trials. Each unit's response to a mismatch is set by a 2-bit policy code. The policy can drop the mismatch, record it in a sticky flag and a saturating counter, or record it and also raise a one-cycle request to move the unit's work elsewhere. If a window closes while only one side of a pair has arrived, the block reports a timeout for that unit.

Top module: `shared_online_checker`

## Requirements
- R1: Units are served in the order 0, 1, …, NUM_UNITS-1, 0, … and `cur_unit_o` stays on unit u for exactly W[u] cycles, where W[u] is the unit's window length; a length of 0 or 1 gives a single cycle.
- R2: In each window `chk_active_o` is low for the first O[u] cycles (the unit's overhead length) and high for the remaining W[u]-O[u] cycles.
- R3: Result strobes seen while `chk_active_o` is low have no effect: they produce no error, no counter change and no timeout.
- R4: A comparison is made once both a monitored and a reference result have been received in the current window. The two may arrive in the same cycle or in different cycles, and only the first result on each side counts. Equal results raise no error.
- R5: A mismatch for a unit with policy code 01 (code 11 acts the same) sets that unit's sticky `err_flag_o` bit and adds one to its counter, both visible in the cycle after the comparison, and does not pulse `migrate_req_o`.
- R6: A mismatch for a unit with policy code 10 does everything R5 does and also pulses that unit's `migrate_req_o` bit for one cycle, in the same cycle as the flag update.
- R7: A mismatch for a unit with policy code 00 changes neither the flag, the counter nor `migrate_req_o`.
- R8: An error counter stops at 2^ERR_W-1 and does not wrap.
- R9: A pulse on `err_clr_i[u]` clears that unit's flag and counter in the next cycle. If an error for the same unit arrives in the same cycle, the clear wins and no migrate pulse is produced.
- R10: When a window ends with exactly one side of a pair received, `timeout_o[u]` pulses for one cycle in the first cycle of the next window, and the lone result is dropped.
- R11: After reset `cur_unit_o` is 0, the window is at its first cycle, and all flags, counters, migrate requests and timeouts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_len_i | input | NUM_UNITS*CNT_W | Window length in cycles, one field per unit |
| ovh_len_i | input | NUM_UNITS*CNT_W | Overhead length in cycles, one field per unit |
| policy_i | input | 2*NUM_UNITS | Error policy per unit: 00 ignore, 01 log, 10 log and migrate, 11 log |
| err_clr_i | input | NUM_UNITS | Clear pulse for each unit's flag and counter |
| mon_vld_i | input | 1 | Monitored unit result valid |
| mon_res_i | input | DATA_W | Monitored unit result |
| ref_vld_i | input | 1 | Reference checker result valid |
| ref_res_i | input | DATA_W | Reference checker result |
| cur_unit_o | output | IDX_W | Unit owning the current window |
| chk_active_o | output | 1 | High in the compare part of the window |
| err_flag_o | output | NUM_UNITS | Sticky error flag per unit |
| err_cnt_o | output | NUM_UNITS*ERR_W | Saturating error count per unit |
| migrate_req_o | output | NUM_UNITS | One-cycle request to move a unit's function |
| timeout_o | output | NUM_UNITS | One-cycle pulse when a window ends with half a pair |

## Verification
The assertions assume that the window and overhead lengths stay constant while the block runs, and that each overhead is shorter than its window. Without that, the compare phase could end early or collapse mid-window, and the properties on phase order and on when comparisons may happen would not be meaningful. The bench fixes all lengths before reset is released and never changes them. It chooses every overhead strictly below its window and launches each result pair only after `chk_active_o` is observed high, so every pair completes inside the window it belongs to.

// File: rtl/shared_chk_pkg.sv
package shared_chk_pkg;
    typedef enum logic [1:0] {
        POL_IGNORE  = 2'd0,
        POL_LOG     = 2'd1,
        POL_MIGRATE = 2'd2,
        POL_RSVD    = 2'd3
    } err_policy_e;
endpackage

// File: rtl/scc_window_seq.sv
module scc_window_seq #(
    parameter int NUM_UNITS = 4,
    parameter int CNT_W     = 16,
    parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_UNITS*CNT_W-1:0] win_len_i,
    input  logic [NUM_UNITS*CNT_W-1:0] ovh_len_i,
    output logic [IDX_W-1:0]           unit_o,
    output logic                       active_o,
    output logic                       last_o
);
    typedef struct packed {
        logic [IDX_W-1:0] unit;
        logic [CNT_W-1:0] tick;
    } seq_t;

    seq_t             st_d, st_q;
    logic [CNT_W-1:0] cur_win;
    logic [CNT_W-1:0] cur_ovh;
    logic             is_last;

    always_comb begin
        st_d    = st_q;
        cur_win = win_len_i[st_q.unit*CNT_W +: CNT_W];
        cur_ovh = ovh_len_i[st_q.unit*CNT_W +: CNT_W];
        is_last = (cur_win <= CNT_W'(1)) || (st_q.tick >= cur_win - CNT_W'(1));
        if (is_last) begin
            st_d.tick = '0;
            st_d.unit = (st_q.unit == IDX_W'(NUM_UNITS - 1)) ? '0 : st_q.unit + IDX_W'(1);
        end else begin
            st_d.tick = st_q.tick + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign unit_o   = st_q.unit;
    assign active_o = (st_q.tick >= cur_ovh);
    assign last_o   = is_last;

    // R1: the owner only changes when a window closes
    p_hold_unit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !last_o |=> $stable(unit_o));

    // R2: once the compare phase opens it stays open to the window end
    p_phase_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !last_o) |=> active_o);
endmodule

// File: rtl/scc_pair_cmp.sv
module scc_pair_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              last_i,
    input  logic              mon_vld_i,
    input  logic [DATA_W-1:0] mon_res_i,
    input  logic              ref_vld_i,
    input  logic [DATA_W-1:0] ref_res_i,
    output logic              evt_o,
    output logic              mism_o,
    output logic              lone_end_o
);
    typedef struct packed {
        logic              mon_have;
        logic              ref_have;
        logic [DATA_W-1:0] mon_val;
        logic [DATA_W-1:0] ref_val;
    } pair_t;

    pair_t             pr_d, pr_q;
    logic              mon_now, ref_now;
    logic [DATA_W-1:0] mon_v, ref_v;

    always_comb begin
        pr_d    = pr_q;
        mon_now = pr_q.mon_have | (active_i & mon_vld_i);
        ref_now = pr_q.ref_have | (active_i & ref_vld_i);
        mon_v   = pr_q.mon_have ? pr_q.mon_val : mon_res_i;
        ref_v   = pr_q.ref_have ? pr_q.ref_val : ref_res_i;
        evt_o      = mon_now & ref_now;
        mism_o     = evt_o & (mon_v != ref_v);
        lone_end_o = last_i & (mon_now ^ ref_now);
        if (evt_o || last_i) begin
            pr_d.mon_have = 1'b0;
            pr_d.ref_have = 1'b0;
        end else begin
            pr_d.mon_have = mon_now;
            pr_d.ref_have = ref_now;
            pr_d.mon_val  = mon_v;
            pr_d.ref_val  = ref_v;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pr_q <= '0;
        else         pr_q <= pr_d;
    end

    // R3: no comparison outside the compare phase
    p_cmp_in_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> active_i);

    // R4: nothing held over into a fresh window
    p_pair_flushed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_i |=> (!pr_q.mon_have && !pr_q.ref_have));
endmodule

// File: rtl/scc_err_bank.sv
module scc_err_bank
    import shared_chk_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ERR_W     = 3,
    parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [IDX_W-1:0]           unit_i,
    input  logic                       mism_i,
    input  logic                       lone_end_i,
    input  logic [2*NUM_UNITS-1:0]     policy_i,
    input  logic [NUM_UNITS-1:0]       clr_i,
    output logic [NUM_UNITS-1:0]       flag_o,
    output logic [NUM_UNITS*ERR_W-1:0] cnt_o,
    output logic [NUM_UNITS-1:0]       mig_o,
    output logic [NUM_UNITS-1:0]       tmo_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    typedef struct packed {
        logic [NUM_UNITS-1:0]            flag;
        logic [NUM_UNITS-1:0][ERR_W-1:0] cnt;
        logic [NUM_UNITS-1:0]            mig;
        logic [NUM_UNITS-1:0]            tmo;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int k = 0; k < NUM_UNITS; k++) begin
            automatic err_policy_e pol = err_policy_e'(policy_i[2*k +: 2]);
            automatic logic        sel = (unit_i == IDX_W'(k));
            automatic logic        hit = mism_i && sel && (pol != POL_IGNORE);
            if (clr_i[k]) begin
                bk_d.flag[k] = 1'b0;
                bk_d.cnt[k]  = '0;
            end else if (hit) begin
                bk_d.flag[k] = 1'b1;
                if (bk_q.cnt[k] != CNT_MAX) bk_d.cnt[k] = bk_q.cnt[k] + ERR_W'(1);
            end
            bk_d.mig[k] = hit && !clr_i[k] && (pol == POL_MIGRATE);
            bk_d.tmo[k] = lone_end_i && sel;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bk_q <= '0;
        else         bk_q <= bk_d;
    end

    assign flag_o = bk_q.flag;
    assign cnt_o  = bk_q.cnt;
    assign mig_o  = bk_q.mig;
    assign tmo_o  = bk_q.tmo;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit_chk
        // R5: a flag only rises after a counted mismatch for this unit
        p_flag_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flag_o[g]) |-> $past(mism_i && unit_i == IDX_W'(g)
                                       && policy_i[2*g +: 2] != 2'b00));
        // R8: the counter never wraps
        p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(cnt_o[g*ERR_W +: ERR_W]) == CNT_MAX && !$past(clr_i[g]))
            |-> cnt_o[g*ERR_W +: ERR_W] == CNT_MAX);
        // R9: a clear empties the unit's record
        p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i[g] |=> (!flag_o[g] && cnt_o[g*ERR_W +: ERR_W] == '0 && !mig_o[g]));
    end
endmodule

// File: rtl/shared_online_checker.sv
module shared_online_checker #(
    parameter int NUM_UNITS = 4,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 16,
    parameter int ERR_W     = 3,
    parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_UNITS*CNT_W-1:0] win_len_i,
    input  logic [NUM_UNITS*CNT_W-1:0] ovh_len_i,
    input  logic [2*NUM_UNITS-1:0]     policy_i,
    input  logic [NUM_UNITS-1:0]       err_clr_i,
    input  logic                       mon_vld_i,
    input  logic [DATA_W-1:0]          mon_res_i,
    input  logic                       ref_vld_i,
    input  logic [DATA_W-1:0]          ref_res_i,
    output logic [IDX_W-1:0]           cur_unit_o,
    output logic                       chk_active_o,
    output logic [NUM_UNITS-1:0]       err_flag_o,
    output logic [NUM_UNITS*ERR_W-1:0] err_cnt_o,
    output logic [NUM_UNITS-1:0]       migrate_req_o,
    output logic [NUM_UNITS-1:0]       timeout_o
);
    logic win_last;
    logic cmp_evt;
    logic cmp_mism;
    logic lone_end;

    scc_window_seq #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .win_len_i(win_len_i),
        .ovh_len_i(ovh_len_i),
        .unit_o   (cur_unit_o),
        .active_o (chk_active_o),
        .last_o   (win_last)
    );

    scc_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (chk_active_o),
        .last_i    (win_last),
        .mon_vld_i (mon_vld_i),
        .mon_res_i (mon_res_i),
        .ref_vld_i (ref_vld_i),
        .ref_res_i (ref_res_i),
        .evt_o     (cmp_evt),
        .mism_o    (cmp_mism),
        .lone_end_o(lone_end)
    );

    scc_err_bank #(.NUM_UNITS(NUM_UNITS), .ERR_W(ERR_W), .IDX_W(IDX_W)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .unit_i    (cur_unit_o),
        .mism_i    (cmp_mism),
        .lone_end_i(lone_end),
        .policy_i  (policy_i),
        .clr_i     (err_clr_i),
        .flag_o    (err_flag_o),
        .cnt_o     (err_cnt_o),
        .mig_o     (migrate_req_o),
        .tmo_o     (timeout_o)
    );

    // R1: owner advances by exactly one step, wrapping to zero
    p_rr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_unit_o != $past(cur_unit_o)) |->
        (cur_unit_o == (($past(cur_unit_o) == IDX_W'(NUM_UNITS - 1)) ? '0
                        : $past(cur_unit_o) + IDX_W'(1))));

    // R6: a migrate request always comes with a raised flag
    p_mig_flagged_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (migrate_req_o & ~err_flag_o) == '0);

    // R10: timeouts appear only right after a window boundary
    p_tmo_at_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o != '0) |-> ($past(win_last) && $onehot0(timeout_o)));
endmodule

// File: tb/shared_online_checker_tb.sv
module shared_online_checker_tb_top;
    localparam int N  = 4;
    localparam int CW = 16;
    localparam int DW = 16;
    localparam int EW = 3;

    typedef struct packed {
        logic [1:0]  u;
        logic [15:0] m;
        logic [15:0] r;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'h1234, 16'h1234},
        '{2'd0, 16'h0001, 16'h0002}, '{2'd0, 16'h00FF, 16'h00FE},
        '{2'd0, 16'hA5A5, 16'h5A5A}, '{2'd0, 16'h8000, 16'h0000},
        '{2'd0, 16'h0010, 16'h0011}, '{2'd0, 16'hFFFF, 16'h7FFF},
        '{2'd0, 16'h0003, 16'h0030}, '{2'd0, 16'h4444, 16'h4445},
        '{2'd0, 16'h0101, 16'h1010},
        '{2'd1, 16'hBEEF, 16'hDEAD},
        '{2'd2, 16'h0707, 16'h0708},
        '{2'd3, 16'h3333, 16'h3333},
        '{2'd3, 16'h3333, 16'h3330}
    };

    localparam int WL [N] = '{12, 10, 14, 8};
    localparam int OL [N] = '{4, 3, 5, 2};
    localparam logic [1:0] PL [N] = '{2'b01, 2'b00, 2'b10, 2'b01};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N*CW-1:0] win_len, ovh_len;
    logic [2*N-1:0]  policy;
    logic [N-1:0]    err_clr = '0;
    logic            mon_vld = 1'b0, ref_vld = 1'b0;
    logic [DW-1:0]   mon_res = '0, ref_res = '0;
    logic [1:0]      cur_unit;
    logic            chk_active;
    logic [N-1:0]    err_flag, migrate_req, timeout;
    logic [N*EW-1:0] err_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int to_seen [N] = '{0, 0, 0, 0};
    int exp_cnt [N] = '{0, 0, 0, 0};
    logic [N-1:0] exp_flag = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_cfg
        assign win_len[g*CW +: CW] = CW'(WL[g]);
        assign ovh_len[g*CW +: CW] = CW'(OL[g]);
        assign policy[2*g +: 2]    = PL[g];
    end

    shared_online_checker #(.NUM_UNITS(N), .CNT_W(CW), .DATA_W(DW), .ERR_W(EW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .win_len_i(win_len), .ovh_len_i(ovh_len),
        .policy_i(policy), .err_clr_i(err_clr), .mon_vld_i(mon_vld), .mon_res_i(mon_res),
        .ref_vld_i(ref_vld), .ref_res_i(ref_res), .cur_unit_o(cur_unit),
        .chk_active_o(chk_active), .err_flag_o(err_flag), .err_cnt_o(err_cnt),
        .migrate_req_o(migrate_req), .timeout_o(timeout)
    );

    always @(negedge clk) begin
        for (int k = 0; k < N; k++) if (timeout[k]) to_seen[k]++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(input int u);
        return int'(err_cnt[u*EW +: EW]);
    endfunction

    task automatic wait_active(input int u);
        while (!(int'(cur_unit) == u && chk_active)) @(negedge clk);
    endtask

    task automatic wait_fresh(input int u);
        while (int'(cur_unit) == u) @(negedge clk);
        while (int'(cur_unit) != u) @(negedge clk);
    endtask

    task automatic model_err(input int u, input bit mism);
        if (mism && PL[u] != 2'b00) begin
            exp_flag[u] = 1'b1;
            if (exp_cnt[u] < 7) exp_cnt[u]++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int len;
        int idle;
        bit mm;
        repeat (3) @(negedge clk);
        // R11: state held in reset
        chk("R11 unit", int'(cur_unit), 0);
        chk("R11 flags", int'(err_flag), 0);
        chk("R11 counters", int'(err_cnt), 0);
        chk("R11 migrate", int'(migrate_req), 0);
        chk("R11 timeout", int'(timeout), 0);
        chk("R11 active", int'(chk_active), 0);
        rst_n = 1'b1;

        // R1, R2: length and phase split of the unit 1 window
        while (int'(cur_unit) != 1) @(negedge clk);
        len = 0;
        idle = 0;
        while (int'(cur_unit) == 1) begin
            len++;
            if (!chk_active) idle++;
            @(negedge clk);
        end
        chk("R1 window length unit1", len, WL[1]);
        chk("R2 overhead length unit1", idle, OL[1]);
        chk("R1 next unit", int'(cur_unit), 2);

        // R3: strobes during overhead of unit 0 are ignored
        wait_fresh(0);
        chk("R3 in overhead", int'(chk_active), 0);
        mon_vld = 1'b1; mon_res = 16'h0001;
        ref_vld = 1'b1; ref_res = 16'h0002;
        @(negedge clk);
        mon_vld = 1'b0; ref_vld = 1'b0;
        mon_vld = 1'b1; mon_res = 16'h0009;
        @(negedge clk);
        mon_vld = 1'b0;
        while (int'(cur_unit) == 0) @(negedge clk);
        @(negedge clk);
        chk("R3 no count", cnt_of(0), 0);
        chk("R3 no flag", int'(err_flag[0]), 0);
        chk("R3 no timeout", to_seen[0], 0);

        // R4..R8: vector table
        for (int i = 0; i < NV; i++) begin
            int u;
            u = int'(VEC[i].u);
            wait_active(u);
            mon_vld = 1'b1; mon_res = VEC[i].m;
            ref_vld = 1'b1; ref_res = VEC[i].r;
            @(negedge clk);
            mon_vld = 1'b0; ref_vld = 1'b0;
            mm = (VEC[i].m != VEC[i].r);
            model_err(u, mm);
            chk("R4/R5/R7/R8 count", cnt_of(u), exp_cnt[u]);
            chk("R5/R7 flag", int'(err_flag[u]), int'(exp_flag[u]));
            chk("R6 migrate", int'(migrate_req[u]), int'(mm && PL[u] == 2'b10));
        end
        chk("R8 saturated", cnt_of(0), 7);
        chk("R7 ignored unit", cnt_of(1), 0);

        // R4: split arrival on unit 2, first result per side kept
        wait_fresh(2);
        wait_active(2);
        mon_vld = 1'b1; mon_res = 16'h00AA;
        @(negedge clk);
        mon_res = 16'h00BB;
        @(negedge clk);
        mon_vld = 1'b0;
        ref_vld = 1'b1; ref_res = 16'h00AA;
        @(negedge clk);
        ref_vld = 1'b0;
        chk("R4 first kept", cnt_of(2), exp_cnt[2]);
        mon_vld = 1'b1; mon_res = 16'h0C0C;
        @(negedge clk);
        mon_vld = 1'b0;
        @(negedge clk);
        ref_vld = 1'b1; ref_res = 16'h0D0D;
        @(negedge clk);
        ref_vld = 1'b0;
        model_err(2, 1'b1);
        chk("R4 split mismatch", cnt_of(2), exp_cnt[2]);
        chk("R6 split migrate", int'(migrate_req[2]), 1);

        // R10: lone result on unit 3
        wait_fresh(3);
        wait_active(3);
        mon_vld = 1'b1; mon_res = 16'h5555;
        @(negedge clk);
        mon_vld = 1'b0;
        while (int'(cur_unit) == 3) @(negedge clk);
        @(negedge clk);
        chk("R10 timeout unit3", to_seen[3], 1);
        chk("R10 no error", cnt_of(3), exp_cnt[3]);

        // R9: clear with a simultaneous error on unit 0
        wait_active(0);
        err_clr[0] = 1'b1;
        mon_vld = 1'b1; mon_res = 16'h0F0F;
        ref_vld = 1'b1; ref_res = 16'h0E0E;
        @(negedge clk);
        err_clr[0] = 1'b0;
        mon_vld = 1'b0; ref_vld = 1'b0;
        chk("R9 count cleared", cnt_of(0), 0);
        chk("R9 flag cleared", int'(err_flag[0]), 0);
        chk("R9 other unit kept", cnt_of(2), exp_cnt[2]);

        finish_run();
    end
endmodule